// File: doc/BRIEF.md
# Store Buffer with Barrier Tracking

This block is a per-core write buffer placed between a processor core and a memory write port. The core sends stores, loads and store-barrier commands on one request port. Stores are queued and sent to memory without waiting for earlier acknowledgements, so writes to different addresses overlap in flight. A load never waits for buffered stores. It is answered one cycle later, either from the newest buffered store to the same address or from a default value that the memory side supplies.

A store barrier occupies its own slot in the queue, in program order with the stores. It leaves the queue only once a counter of issued but unacknowledged writes has returned to zero. Every store queued behind it is held until that happens. Two stores to the same address are never in flight together. Memory acknowledges writes in the order they were issued. A store leaves the buffer when its acknowledgement arrives, and loads can see its value until then.

Top module: `store_fence_buffer`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full`, `err` and `ld_valid` are 0, and `outstanding` is 0.
- R2: Request encoding on `req_kind`: 2'b00 load, 2'b01 store, 2'b10 barrier. When all DEPTH slots are occupied, `full` is 1 and `req_ready` is 0 for stores and barriers, which are then not accepted. Loads are always accepted.
- R3: Stores appear on the memory port in program order with their own address and data. `outstanding` rises by one for each issued write and falls by one for each acknowledgement.
- R4: Stores to different addresses with no barrier between them are issued back to back without waiting for acknowledgements, up to DEPTH in flight.
- R5: A store queued after a barrier is not issued until every store before the barrier has been acknowledged.
- R6: A load gets its response on `ld_valid`/`ld_data` in the cycle after it is accepted. If no buffered store matches its address, the response is `miss_data`.
- R7: A load to an address with buffered stores returns the newest buffered value for that address, whether that store is still waiting or already issued and unacknowledged.
- R8: A store whose address matches an issued, unacknowledged store is not issued until that older store is acknowledged.
- R9: An acknowledgement that arrives while `outstanding` is 0 sets `err`, leaves the counter at 0, and `err` stays set until reset.
- R10: `empty` is 1 exactly when the buffer holds no entries and `outstanding` is 0.
- R11: An acknowledged store leaves the buffer, and later loads to its address return `miss_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 00 load, 01 store, 10 barrier |
| req_addr | input | AW | Request address |
| req_data | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| miss_data | input | DW | Value returned for loads that match no buffered store |
| ld_valid | output | 1 | Load response valid |
| ld_data | output | DW | Load response data |
| mem_wr_valid | output | 1 | Write request to memory |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_wr_ready | input | 1 | Memory takes the write request |
| mem_ack | input | 1 | Write acknowledgement, in issue order |
| outstanding | output | $clog2(DEPTH+1) | Issued, unacknowledged writes |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No entries and nothing outstanding |
| err | output | 1 | Sticky flag for an acknowledgement with no write outstanding |

## Verification
The checker tests these properties on every cycle:
- The outstanding counter rises by exactly one for each issued write and falls by exactly one for each acknowledgement, and it never exceeds the depth.
- A full buffer refuses stores and barriers, while loads are always accepted and answered one cycle later.
- `err` is set by a spurious acknowledgement and stays set.
- `empty` implies that no write is outstanding or being requested.

Some behaviour depends on what is held in the queue, and only the bench scenarios show it:
- A barrier holds back the stores behind it.
- A same-address store waits behind an older in-flight one.
- Forwarding picks the newest matching value.
- An acknowledged store disappears from the forwarding path.

// File: rtl/store_fence_buffer.sv
module store_fence_buffer #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [1:0]                   req_kind,
  input  logic [AW-1:0]                req_addr,
  input  logic [DW-1:0]                req_data,
  output logic                         req_ready,
  input  logic [DW-1:0]                miss_data,
  output logic                         ld_valid,
  output logic [DW-1:0]                ld_data,
  output logic                         mem_wr_valid,
  output logic [AW-1:0]                mem_wr_addr,
  output logic [DW-1:0]                mem_wr_data,
  input  logic                         mem_wr_ready,
  input  logic                         mem_ack,
  output logic [$clog2(DEPTH+1)-1:0]   outstanding,
  output logic                         full,
  output logic                         empty,
  output logic                         err
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [1:0] KLD = 2'b00, KST = 2'b01, KBAR = 2'b10;

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [DEPTH-1:0] e_bar;
  logic [PW-1:0]    head, tail, iss;
  logic [CW-1:0]    used, cnt;
  logic             err_q, ld_v;
  logic [DW-1:0]    ld_d;
  logic             conflict, fwd_hit;
  logic [DW-1:0]    fwd_data;

  // Slots [head, head+cnt) hold issued stores; iss is the next slot to issue.
  assign iss = head + cnt[PW-1:0];

  always_comb begin
    conflict = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if (CW'(k) < cnt && e_addr[head + PW'(k)] == e_addr[iss]) conflict = 1'b1;
  end

  // Oldest to newest: the last match is the youngest store.
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CW'(k) < used && !e_bar[head + PW'(k)] && e_addr[head + PW'(k)] == req_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = e_data[head + PW'(k)];
      end
  end

  logic have_new, fire, bar_ret, ack_ok, deq, enq, ld_req;
  assign have_new     = used != cnt;
  assign mem_wr_valid = have_new && !e_bar[iss] && !conflict;
  assign mem_wr_addr  = e_addr[iss];
  assign mem_wr_data  = e_data[iss];
  assign fire         = mem_wr_valid && mem_wr_ready;
  assign bar_ret      = have_new && e_bar[iss] && cnt == '0;
  assign ack_ok       = mem_ack && cnt != '0;
  assign deq          = ack_ok || bar_ret;
  assign full         = used == CW'(DEPTH);
  assign req_ready    = (req_kind == KLD) || !full;
  assign enq          = req_valid && !full && (req_kind == KST || req_kind == KBAR);
  assign ld_req       = req_valid && req_kind == KLD;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      used  <= '0;
      cnt   <= '0;
      err_q <= 1'b0;
      ld_v  <= 1'b0;
    end else begin
      if (enq) tail <= tail + 1'b1;
      if (deq) head <= head + 1'b1;
      used  <= used + CW'(enq) - CW'(deq);
      cnt   <= cnt + CW'(fire) - CW'(ack_ok);
      err_q <= err_q || (mem_ack && cnt == '0);
      ld_v  <= ld_req;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      e_addr[tail] <= req_addr;
      e_data[tail] <= req_data;
      e_bar[tail]  <= req_kind == KBAR;
    end
    if (ld_req) ld_d <= fwd_hit ? fwd_data : miss_data;
  end

  assign outstanding = cnt;
  assign empty       = used == '0 && cnt == '0;
  assign err         = err_q;
  assign ld_valid    = ld_v;
  assign ld_data     = ld_d;
endmodule

module store_fence_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic          req_ready,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic          mem_ack,
  input logic [CW-1:0] outstanding,
  input logic          full,
  input logic          empty,
  input logic          err,
  input logic          ld_valid
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CW'(DEPTH)); // R3
  AST_ISSUE_INC: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && mem_wr_ready && !mem_ack) |=> outstanding == $past(outstanding) + 1'b1); // R3
  AST_ACK_DEC: assert property (@(posedge clk) disable iff (rst)
    (mem_ack && !(mem_wr_valid && mem_wr_ready) && outstanding != '0) |=> outstanding == $past(outstanding) - 1'b1); // R3
  AST_ZERO_ACK_ERR: assert property (@(posedge clk) disable iff (rst)
    (mem_ack && outstanding == '0) |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (full && req_valid && req_kind != 2'b00) |-> !req_ready); // R2
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00) |-> req_ready); // R2
  AST_LOAD_RESP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00) |=> ld_valid); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    empty |-> (outstanding == '0 && !mem_wr_valid && !full)); // R10
endmodule

bind store_fence_buffer store_fence_buffer_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_ack(mem_ack),
  .outstanding(outstanding), .full(full), .empty(empty), .err(err), .ld_valid(ld_valid)
);

// File: tb/store_fence_buffer_tb.sv
module store_fence_buffer_tb;
  localparam int DEPTH = 8, AW = 16, DW = 32, CW = $clog2(DEPTH+1);
  localparam logic [1:0] KLD = 2'b00, KST = 2'b01, KBAR = 2'b10;
  localparam logic [DW-1:0] MISS = 32'hDEAD_BEEF;

  logic clk = 0, rst = 1;
  logic req_valid = 0, mready = 0, mem_ack = 0;
  logic [1:0] req_kind = KLD;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, ld_valid, mem_wr_valid, full, empty, err;
  logic [DW-1:0] ld_data, mem_wr_data;
  logic [AW-1:0] mem_wr_addr;
  logic [CW-1:0] outstanding;

  int checks = 0, errors = 0;
  logic [DW-1:0] ld_q[$];
  string ld_tag[$];
  logic [AW+DW-1:0] wr_q[$];

  always #10 clk = ~clk;

  store_fence_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .miss_data(MISS), .ld_valid(ld_valid),
    .ld_data(ld_data), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mready), .mem_ack(mem_ack),
    .outstanding(outstanding), .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output bit acc);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = a; req_data = d;
    #1 acc = req_ready;
    if (acc && kind == KST) wr_q.push_back({a, d});
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit acc;
    send(KST, a, d, acc);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    bit acc;
    @(negedge clk);
    ld_q.push_back(exp);
    ld_tag.push_back(tag);
    req_valid = 1; req_kind = KLD; req_addr = a;
    #1 acc = req_ready;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); mem_ack = 1;
    @(posedge clk); #1 mem_ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    #5;
    if (!rst) begin
      if (ld_valid) begin
        if (ld_q.size() == 0) chk("R6 unexpected load response", 1, 0);
        else chk(ld_tag.pop_front(), ld_data, ld_q.pop_front());
      end
      if (mem_wr_valid && mready) begin
        if (wr_q.size() == 0) chk("R3 unexpected memory write", 1, 0);
        else chk("R3 write order", {mem_wr_addr, mem_wr_data}, wr_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 err", err, 0);
    chk("R1 outstanding", outstanding, 0); chk("R1 ld_valid", ld_valid, 0);

    // forwarding from waiting stores, miss path, overlapped issue
    store(16'h0010, 32'h111); store(16'h0020, 32'h222);
    load(16'h0010, 32'h111, "R7 forward waiting store");
    load(16'h0030, MISS, "R6 load miss");
    idle(2);
    chk("R3 no issue while not ready", outstanding, 0);
    @(negedge clk) mready = 1;
    idle(3);
    chk("R4 two in flight", outstanding, 2);
    chk("R10 not empty", empty, 0);
    load(16'h0020, 32'h222, "R7 forward issued store");
    idle(2);
    ack(); ack(); idle(2);
    chk("R3 drained", outstanding, 0);
    chk("R10 empty after drain", empty, 1);
    load(16'h0010, MISS, "R11 acked store gone");

    // same address
    store(16'h0040, 32'hA1); store(16'h0040, 32'hA2);
    idle(3);
    chk("R8 one in flight", outstanding, 1);
    load(16'h0040, 32'hA2, "R7 newest value");
    ack(); idle(3);
    chk("R8 second issued", outstanding, 1);
    ack(); idle(2);
    chk("R10 empty", empty, 1);

    // barrier
    store(16'h0050, 32'hB1);
    send(KBAR, '0, '0, acc);
    store(16'h0060, 32'hB2);
    idle(3);
    chk("R5 held behind barrier", outstanding, 1);
    load(16'h0060, 32'hB2, "R7 forward behind barrier");
    ack(); idle(3);
    chk("R5 released", outstanding, 1);
    ack(); idle(2);
    chk("R10 empty", empty, 1);

    // full
    @(negedge clk) mready = 0;
    for (int i = 0; i < DEPTH; i++) store(16'h0100 + AW'(i), 32'hC0 + DW'(i));
    @(negedge clk);
    chk("R2 full", full, 1);
    send(KST, 16'h0200, 32'h55, acc);
    chk("R2 store refused", acc, 0);
    send(KBAR, '0, '0, acc);
    chk("R2 barrier refused", acc, 0);
    load(16'h0103, 32'hC3, "R2 load while full");
    @(negedge clk) mready = 1;
    idle(12);
    chk("R4 all in flight", outstanding, DEPTH);
    for (int i = 0; i < DEPTH; i++) ack();
    idle(2);
    chk("R10 empty", empty, 1);
    load(16'h0200, MISS, "R2 refused store absent");

    // spurious ack
    ack(); idle(2);
    chk("R9 err set", err, 1);
    chk("R9 counter stays zero", outstanding, 0);
    idle(3);
    chk("R9 err sticky", err, 1);

    idle(2);
    chk("R3 all writes seen", wr_q.size(), 0);
    chk("R6 all loads answered", ld_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule